// File: doc/BRIEF.md
# Outbound Message Descriptor Queue

This block tracks a circular ring of fixed-size message descriptors that software builds in memory for an outbound messaging engine. Software programs the ring's base through either pointer register, sets the ring depth and interrupt enables in a mode register, and posts each new descriptor by writing the mode register with an increment strobe bit set. The enqueue pointer then moves forward by one 32-byte slot, wrapping at the end of the ring.

While the unit is enabled and the ring holds posted work, the block reads the four words of the descriptor at the dequeue pointer through a simple read port. It presents the decoded fields (destination ID, mailbox, attributes, source address, transfer size) on a send-request handshake and waits for the engine's completion pulse. On completion the dequeue pointer moves to the next slot and sticky status flags record the event. A single interrupt line is the OR of the status flags, each masked by its own enable.

Top module: `msg_desc_queue`

## Requirements
- R1: After reset the mode register reads 0x3A0 (unit off, depth field 0, interrupt enables for end-of-message, queue-full, overflow and error), the status register reads 0, both pointer registers read 0 and irq is low.
- R2: Register select 2 is the dequeue pointer and 3 the enqueue pointer. Writing either one loads the ring base with the written value's low 5 bits cleared and resets that pointer to the base. A pointer reads as base plus 32 times its slot index.
- R3: A write to register select 0 (mode) with bit 1 set advances the enqueue pointer by 32 bytes, returning to the base after the last slot. The ring has 2^(F+1) slots, where F is mode bits 15:12, with F values above 10 treated as 10. Bit 1 always reads back as 0.
- R4: The ring is full when advancing the enqueue index would make it equal the dequeue index. An accepted increment that leaves the ring full sets status bit 4 (queue full).
- R5: An increment request while the ring is full sets status bit 5 (overflow) and leaves the enqueue pointer unchanged.
- R6: While mode bit 0 is set and the ring is not empty, the block reads four words at the dequeue pointer plus 0, 4, 8 and 12. Each read request and its address are held until memRdValid returns the data.
- R7: Word 0 gives the destination ID (bits 31:16) and mailbox (bits 1:0). Words 1, 2 and 3 give the attribute, the source address and the transfer size. All of these are driven with sendValid and held until sendReady.
- R8: On sendDone the dequeue pointer advances by one slot, wrapping at the ring end, and status bit 1 (end of message) is set. If sendError is high with sendDone, status bit 7 (transfer error) is set as well.
- R9: When a completion leaves the dequeue index equal to the enqueue index, status bit 0 (queue empty) is set. No fetch starts while the ring is empty.
- R10: Status bit 2 (busy) is high from the start of a fetch until its completion. If mode bit 0 is cleared, the transfer in progress still completes, then no further fetch starts and busy reads 0.
- R11: Writing the status register clears each sticky bit written as 1. Bits written as 0 keep their value, and the busy bit is not affected.
- R12: irq is the OR of the status bits, each gated by its enable in mode bits 9:4: bit 4 gates queue empty, 5 end of message, 6 busy, 7 queue full, 8 overflow and 9 transfer error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 mode, 1 status, 2 dequeue pointer, 3 enqueue pointer |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| memRdReq | output | 1 | Descriptor word read request, held until memRdValid |
| memRdAddr | output | 32 | Byte address of the requested descriptor word |
| memRdValid | input | 1 | Read data valid; also completes the request |
| memRdData | input | 32 | Descriptor word read data |
| sendValid | output | 1 | Message-send request valid |
| sendReady | input | 1 | Send engine accepts the request |
| sendDestId | output | 16 | Destination ID of the message |
| sendMbox | output | 2 | Target mailbox |
| sendAttr | output | 32 | Descriptor attribute word |
| sendSrcAddr | output | 32 | Source buffer address |
| sendSize | output | 32 | Transfer size in bytes |
| sendDone | input | 1 | One-cycle pulse when the accepted message has been sent |
| sendError | input | 1 | Qualifies sendDone: the transfer failed |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions watch, on every cycle, that a pending descriptor read keeps its request and word index steady and that a send request stays up until it is accepted. They also check that no fetch starts while the unit is off or the ring is empty, that a completion always leaves end-of-message (and on error, transfer error) set, and that a rejected increment leaves the enqueue index where it was. Only the bench's scenarios can show that the ring wraps at the programmed depth, where full, overflow and empty are flagged, and that disabling the unit mid-transfer finishes exactly one descriptor. The same applies to write-one-to-clear behaviour and to the mapping of each enable bit onto irq, which the reference model compares cycle by cycle.

// File: rtl/mdq_pkg.sv
package mdq_pkg;

  localparam int WORD_W        = 32;
  localparam int DESC_SHIFT    = 5;   // 32-byte descriptor slots
  localparam int WORD_SHIFT    = 2;   // 4-byte words
  localparam int DESC_WORDS    = 4;
  localparam int WSEL_W        = $clog2(DESC_WORDS);
  localparam int STAT_N        = 6;

  // internal status vector indices
  localparam int ST_QE   = 0;
  localparam int ST_EOM  = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_QF   = 3;
  localparam int ST_QO   = 4;
  localparam int ST_TE   = 5;

  // bit position of each internal status bit in the status register
  localparam int STAT_POS [STAT_N] = '{0, 1, 2, 4, 5, 7};

  localparam logic [STAT_N-1:0] INT_EN_RESET = 6'b111010;

  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_STATUS = 2'd1,
    REG_DEQ    = 2'd2,
    REG_ENQ    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              capture;
    logic [WSEL_W-1:0] word;
    logic              finish;
    logic              finishErr;
    logic              busy;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [15:0]       destId;
    logic [1:0]        mbox;
    logic [WORD_W-1:0] attr;
    logic [WORD_W-1:0] srcAddr;
    logic [WORD_W-1:0] xferSize;
  } desc_t;

endpackage

// File: rtl/mdq_ctrl.sv
module mdq_ctrl
  import mdq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unitEnable,
  input  logic        queueEmpty,
  input  logic        memRdValid,
  input  logic        sendReady,
  input  logic        sendDone,
  input  logic        sendError,
  output logic        memRdReq,
  output logic        sendValid,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND, S_WAIT} state_e;

  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(DESC_WORDS - 1);

  state_e            state;
  logic [WSEL_W-1:0] wordCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wordCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          wordCnt <= '0;
          if (unitEnable && !queueEmpty) state <= S_FETCH;
        end
        S_FETCH: begin
          if (memRdValid) begin
            if (wordCnt == LAST_WORD) begin
              state   <= S_SEND;
              wordCnt <= '0;
            end else begin
              wordCnt <= wordCnt + WSEL_W'(1);
            end
          end
        end
        S_SEND: if (sendReady) state <= S_WAIT;
        S_WAIT: if (sendDone) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    memRdReq         = (state == S_FETCH);
    sendValid        = (state == S_SEND);
    strobe.capture   = (state == S_FETCH) && memRdValid;
    strobe.word      = wordCnt;
    strobe.finish    = (state == S_WAIT) && sendDone;
    strobe.finishErr = (state == S_WAIT) && sendDone && sendError;
    strobe.busy      = (state != S_IDLE);
  end

  // R6
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRdReq && !memRdValid |=> memRdReq && (strobe.word == $past(strobe.word)));

  // R7
  send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sendValid && !sendReady |=> sendValid);

  // R10
  no_idle_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memRdReq) |-> $past(unitEnable) && !$past(queueEmpty));

endmodule

// File: rtl/mdq_datapath.sv
module mdq_datapath
  import mdq_pkg::*;
#(
  parameter int MAX_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] memRdAddr,
  output logic              unitEnable,
  output logic              queueEmpty,
  output desc_t             desc,
  output logic              irq
);

  localparam int IDX_W     = MAX_LOG2;
  localparam int FIELD_W   = 4;
  localparam logic [FIELD_W-1:0] MAX_FIELD = FIELD_W'(MAX_LOG2 - 1);

  logic [FIELD_W-1:0] modeSize;
  logic [STAT_N-1:0]  intEn;
  logic [WORD_W-1:0]  ringBase;
  logic [IDX_W-1:0]   enqIdx, deqIdx;
  logic [STAT_N-1:0]  stat, statNext, statVec;

  logic wrMode, wrStatus, wrEnq, wrDeq, incReq, queueFull;
  logic [FIELD_W-1:0] fieldEff;
  logic [IDX_W-1:0]   idxMask, enqNext, enqNext2, deqNext;

  assign wrMode   = regWrEn && (regAddr == REG_MODE);
  assign wrStatus = regWrEn && (regAddr == REG_STATUS);
  assign wrDeq    = regWrEn && (regAddr == REG_DEQ);
  assign wrEnq    = regWrEn && (regAddr == REG_ENQ);
  assign incReq   = wrMode && regWrData[1];

  assign fieldEff  = (modeSize > MAX_FIELD) ? MAX_FIELD : modeSize;
  assign idxMask   = ~({IDX_W{1'b1}} << (fieldEff + FIELD_W'(1)));
  assign enqNext   = (enqIdx + IDX_W'(1)) & idxMask;
  assign enqNext2  = (enqNext + IDX_W'(1)) & idxMask;
  assign deqNext   = (deqIdx + IDX_W'(1)) & idxMask;
  assign queueEmpty = (enqIdx == deqIdx);
  assign queueFull  = (enqNext == deqIdx);

  // mode and pointer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unitEnable <= 1'b0;
      intEn      <= INT_EN_RESET;
      modeSize   <= '0;
      ringBase   <= '0;
      enqIdx     <= '0;
      deqIdx     <= '0;
    end else begin
      if (wrMode) begin
        unitEnable <= regWrData[0];
        intEn      <= regWrData[9:4];
        modeSize   <= regWrData[15:12];
      end
      if (wrEnq) begin
        ringBase <= {regWrData[WORD_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
        enqIdx   <= '0;
      end else if (incReq && !queueFull) begin
        enqIdx <= enqNext;
      end
      if (wrDeq) begin
        ringBase <= {regWrData[WORD_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
        deqIdx   <= '0;
      end else if (strobe.finish) begin
        deqIdx <= deqNext;
      end
    end
  end

  // sticky status: write-one-to-clear, set has priority
  always_comb begin
    statNext = stat;
    if (wrStatus) begin
      for (int i = 0; i < STAT_N; i++) begin
        if (regWrData[STAT_POS[i]]) statNext[i] = 1'b0;
      end
    end
    if (incReq && queueFull)                         statNext[ST_QO] = 1'b1;
    if (incReq && !queueFull && (enqNext2 == deqIdx)) statNext[ST_QF] = 1'b1;
    if (strobe.finish) begin
      statNext[ST_EOM] = 1'b1;
      if (strobe.finishErr)    statNext[ST_TE] = 1'b1;
      if (deqNext == enqIdx)   statNext[ST_QE] = 1'b1;
    end
    statNext[ST_BUSY] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= statNext;
  end

  always_comb begin
    statVec          = stat;
    statVec[ST_BUSY] = strobe.busy;
  end

  assign irq = |(statVec & intEn);

  // descriptor capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc <= '0;
    end else if (strobe.capture) begin
      case (strobe.word)
        WSEL_W'(0): begin
          desc.destId <= memRdData[31:16];
          desc.mbox   <= memRdData[1:0];
        end
        WSEL_W'(1): desc.attr     <= memRdData;
        WSEL_W'(2): desc.srcAddr  <= memRdData;
        default:    desc.xferSize <= memRdData;
      endcase
    end
  end

  assign memRdAddr = ringBase + (WORD_W'(deqIdx) << DESC_SHIFT)
                              + (WORD_W'(strobe.word) << WORD_SHIFT);

  // register read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_MODE: begin
        regRdData[0]     = unitEnable;
        regRdData[9:4]   = intEn;
        regRdData[15:12] = modeSize;
      end
      REG_STATUS: begin
        for (int i = 0; i < STAT_N; i++) regRdData[STAT_POS[i]] = statVec[i];
      end
      REG_DEQ: regRdData = ringBase + (WORD_W'(deqIdx) << DESC_SHIFT);
      default: regRdData = ringBase + (WORD_W'(enqIdx) << DESC_SHIFT);
    endcase
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    incReq && queueFull |=> $stable(enqIdx));

  // R8
  eom_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.finish |=> stat[ST_EOM]);

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.finishErr |=> stat[ST_TE]);

endmodule

// File: rtl/msg_desc_queue.sv
module msg_desc_queue
  import mdq_pkg::*;
#(
  parameter int MAX_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              memRdReq,
  output logic [WORD_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [WORD_W-1:0] memRdData,
  output logic              sendValid,
  input  logic              sendReady,
  output logic [15:0]       sendDestId,
  output logic [1:0]        sendMbox,
  output logic [WORD_W-1:0] sendAttr,
  output logic [WORD_W-1:0] sendSrcAddr,
  output logic [WORD_W-1:0] sendSize,
  input  logic              sendDone,
  input  logic              sendError,
  output logic              irq
);

  ctrlStrobe_t strobe;
  desc_t       desc;
  logic        unitEnable, queueEmpty;

  mdq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .unitEnable (unitEnable),
    .queueEmpty (queueEmpty),
    .memRdValid (memRdValid),
    .sendReady  (sendReady),
    .sendDone   (sendDone),
    .sendError  (sendError),
    .memRdReq   (memRdReq),
    .sendValid  (sendValid),
    .strobe     (strobe)
  );

  mdq_datapath #(.MAX_LOG2(MAX_LOG2)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .strobe     (strobe),
    .memRdData  (memRdData),
    .memRdAddr  (memRdAddr),
    .unitEnable (unitEnable),
    .queueEmpty (queueEmpty),
    .desc       (desc),
    .irq        (irq)
  );

  assign sendDestId  = desc.destId;
  assign sendMbox    = desc.mbox;
  assign sendAttr    = desc.attr;
  assign sendSrcAddr = desc.srcAddr;
  assign sendSize    = desc.xferSize;

endmodule

// File: tb/msg_desc_queue_test.sv
`timescale 1ns/100ps
module msg_desc_queue_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        sendValid;
  logic        sendReady = 1'b0;
  logic [15:0] sendDestId;
  logic [1:0]  sendMbox;
  logic [31:0] sendAttr, sendSrcAddr, sendSize;
  logic        sendDone = 1'b0;
  logic        sendError = 1'b0;
  logic        irq;

  msg_desc_queue uut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .sendValid(sendValid), .sendReady(sendReady), .sendDestId(sendDestId),
    .sendMbox(sendMbox), .sendAttr(sendAttr), .sendSrcAddr(sendSrcAddr),
    .sendSize(sendSize), .sendDone(sendDone), .sendError(sendError), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // reference model state
  logic [31:0] mBase = '0;
  int          mEnq = 0, mDeq = 0, mField = 0;
  logic [5:0]  mIntEn = 6'b111010;
  bit          mEn = 1'b0;
  logic [5:0]  mStat = '0;   // 0 QE,1 EOM,2 unused,3 QF,4 QO,5 TE

  int  doneDelay = 2;
  bit  nextErr = 1'b0;
  int  fetchSeen = 0;

  function automatic logic [31:0] memWord(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A3C_0F96;
  endfunction

  function automatic int mMask();
    int f = (mField > 10) ? 10 : mField;
    return (2 << f) - 1;
  endfunction

  function automatic logic [31:0] statWord(bit busy);
    logic [31:0] w = '0;
    w[0] = mStat[0]; w[1] = mStat[1]; w[2] = busy;
    w[4] = mStat[3]; w[5] = mStat[4]; w[7] = mStat[5];
    return w;
  endfunction

  function automatic logic [31:0] modeWord(int field, logic [5:0] ie, bit en, bit inc);
    return (32'(field) << 12) | (32'(ie) << 4) | (32'(inc) << 1) | 32'(en);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    int newEnq = mEnq;
    bit ovf = 1'b0, qf = 1'b0;
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    if (a == 2'd0 && d[1]) begin
      if (((mEnq + 1) & mMask()) == mDeq) ovf = 1'b1;
      else begin
        newEnq = (mEnq + 1) & mMask();
        qf = (((newEnq + 1) & mMask()) == mDeq);
      end
    end
    @(posedge clk); #1;
    regWrEn = 1'b0;
    case (a)
      2'd0: begin
        mEnq = newEnq;
        if (ovf) mStat[4] = 1'b1;
        if (qf)  mStat[3] = 1'b1;
        mEn = d[0]; mIntEn = d[9:4]; mField = int'(d[15:12]);
      end
      2'd1: begin
        if (d[0]) mStat[0] = 1'b0;
        if (d[1]) mStat[1] = 1'b0;
        if (d[4]) mStat[3] = 1'b0;
        if (d[5]) mStat[4] = 1'b0;
        if (d[7]) mStat[5] = 1'b0;
      end
      2'd2: begin mBase = {d[31:5], 5'b0}; mDeq = 0; end
      default: begin mBase = {d[31:5], 5'b0}; mEnq = 0; end
    endcase
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic incr();
    wrReg(2'd0, modeWord(mField, mIntEn, mEn, 1'b1));
  endtask

  // memory and send-engine responder, per-cycle comparison
  initial begin
    int  fw = 0, cnt = 0, pendDeq = 0;
    bit  sendPend = 0, doneArmed = 0, pendQe = 0, pendErr = 0;
    logic [31:0] a;
    sendReady = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (doneArmed) begin
        mDeq = pendDeq;
        mStat[1] = 1'b1;
        if (pendQe)  mStat[0] = 1'b1;
        if (pendErr) mStat[5] = 1'b1;
        sendDone = 1'b0; sendError = 1'b0; doneArmed = 0;
      end
      @(negedge clk);
      if (rst_n) begin
        check("R12", "irq", 32'(irq), 32'(|(mStat & mIntEn)));
        if (memRdReq) begin
          fetchSeen++;
          a = mBase + 32'(mDeq * 32 + fw * 4);
          check("R6", "fetch address", memRdAddr, a);
          memRdValid = 1'b1;
          memRdData  = memWord(a);
          fw = (fw + 1) % 4;
        end else begin
          memRdValid = 1'b0;
        end
        if (sendValid && !sendPend) begin
          a = mBase + 32'(mDeq * 32);
          check("R7", "destId", 32'(sendDestId), 32'(memWord(a) >> 16));
          check("R7", "mbox",   32'(sendMbox),   32'(memWord(a) & 32'h3));
          check("R7", "attr",   sendAttr,    memWord(a + 4));
          check("R7", "srcAddr", sendSrcAddr, memWord(a + 8));
          check("R7", "size",   sendSize,    memWord(a + 12));
          sendPend = 1; cnt = doneDelay;
        end else if (sendPend) begin
          cnt--;
          if (cnt == 0) begin
            sendPend = 0;
            sendDone = 1'b1; sendError = nextErr;
            pendDeq = (mDeq + 1) & mMask();
            pendQe  = (pendDeq == mEnq);
            pendErr = nextErr;
            doneArmed = 1;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int fs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdReg(2'd0, d); check("R1", "mode", d, 32'h3A0);
    rdReg(2'd1, d); check("R1", "status", d, 32'h0);
    rdReg(2'd2, d); check("R1", "deq ptr", d, 32'h0);
    rdReg(2'd3, d); check("R1", "enq ptr", d, 32'h0);
    check("R1", "irq", 32'(irq), 32'h0);

    // R2 pointer writes
    wrReg(2'd2, 32'h1000_0047);
    wrReg(2'd3, 32'h1000_0040);
    rdReg(2'd2, d); check("R2", "deq ptr", d, 32'h1000_0040);
    rdReg(2'd3, d); check("R2", "enq ptr", d, 32'h1000_0040);

    // R3 R4 R5 four-slot ring, unit off
    wrReg(2'd0, modeWord(1, 6'b111010, 1'b0, 1'b0));
    incr(); incr();
    rdReg(2'd3, d); check("R3", "enq ptr after 2", d, 32'h1000_0080);
    rdReg(2'd0, d); check("R3", "inc bit reads 0", d & 32'h2, 32'h0);
    rdReg(2'd1, d); check("R4", "not yet full", d, 32'h0);
    incr();
    rdReg(2'd1, d); check("R4", "queue full", d, 32'h10);
    check("R4", "irq on full", 32'(irq), 32'h1);
    incr();
    rdReg(2'd3, d); check("R5", "enq ptr unchanged", d, 32'h1000_00A0);
    rdReg(2'd1, d); check("R5", "overflow", d, 32'h30);
    check("R10", "no fetch while off", 32'(fetchSeen), 32'h0);
    wrReg(2'd1, 32'h30);
    rdReg(2'd1, d); check("R11", "w1c clear", d, 32'h0);

    // R6 R7 R8 R9 process three descriptors
    wrReg(2'd0, modeWord(1, 6'b111010, 1'b1, 1'b0));
    repeat (60) @(negedge clk);
    rdReg(2'd2, d); check("R8", "deq ptr", d, 32'h1000_00A0);
    rdReg(2'd1, d); check("R9", "eom and empty", d, 32'h03);
    check("R12", "irq from eom", 32'(irq), 32'h1);
    wrReg(2'd1, 32'h0);
    rdReg(2'd1, d); check("R11", "zero write keeps", d, 32'h03);
    wrReg(2'd1, 32'h02);
    rdReg(2'd1, d); check("R11", "eom cleared", d, 32'h01);
    check("R12", "empty not enabled", 32'(irq), 32'h0);
    wrReg(2'd0, modeWord(1, 6'b111011, 1'b1, 1'b0));
    check("R12", "empty enabled", 32'(irq), 32'h1);
    wrReg(2'd1, 32'h01);
    check("R12", "empty cleared", 32'(irq), 32'h0);
    wrReg(2'd0, modeWord(1, 6'b111010, 1'b1, 1'b0));

    // R3 R8 wrap with transfer errors
    nextErr = 1'b1;
    incr(); incr();
    rdReg(2'd3, d); check("R3", "enq wrap", d, 32'h1000_0060);
    repeat (60) @(negedge clk);
    rdReg(2'd2, d); check("R8", "deq wrap", d, 32'h1000_0060);
    rdReg(2'd1, d); check("R8", "error status", d, 32'h83);
    wrReg(2'd1, 32'hB3);
    nextErr = 1'b0;

    // R10 disable during a transfer
    doneDelay = 20;
    incr(); incr();
    begin
      int guard = 0;
      while (!sendValid && guard < 100) begin @(negedge clk); guard++; end
    end
    wrReg(2'd0, modeWord(1, 6'b111010, 1'b0, 1'b0));
    rdReg(2'd1, d); check("R10", "busy during transfer", (d >> 2) & 32'h1, 32'h1);
    fs = fetchSeen;
    repeat (60) @(negedge clk);
    rdReg(2'd2, d); check("R10", "one completed", d, 32'h1000_0080);
    check("R10", "no new fetch", 32'(fetchSeen), 32'(fs));
    rdReg(2'd1, d); check("R10", "busy cleared", d, 32'h02);
    wrReg(2'd0, modeWord(1, 6'b111010, 1'b1, 1'b0));
    repeat (60) @(negedge clk);
    rdReg(2'd2, d); check("R9", "drained", d, 32'h1000_00A0);
    rdReg(2'd1, d); check("R9", "empty again", d, 32'h03);
    wrReg(2'd1, 32'h03);
    doneDelay = 2;

    // R3 R4 two-slot ring and depth cap
    wrReg(2'd0, modeWord(0, 6'b111010, 1'b0, 1'b0));
    wrReg(2'd2, 32'h2000_0000);
    wrReg(2'd3, 32'h2000_0000);
    incr();
    rdReg(2'd1, d); check("R4", "two-slot full", d, 32'h10);
    incr();
    rdReg(2'd3, d); check("R5", "two-slot enq", d, 32'h2000_0020);
    rdReg(2'd1, d); check("R5", "two-slot overflow", d, 32'h30);
    wrReg(2'd1, 32'h30);
    wrReg(2'd0, modeWord(15, 6'b111010, 1'b0, 1'b0));
    wrReg(2'd3, 32'h2000_0000);
    wrReg(2'd2, 32'h2000_0000);
    incr(); incr();
    rdReg(2'd3, d); check("R3", "capped depth", d, 32'h2000_0040);
    rdReg(2'd1, d); check("R3", "no full at cap", d, 32'h0);
    check("R10", "busy idle", 32'(statWord(1'b0)), 32'h0);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule